// File: doc/BRIEF.md
# Linked-List Free Buffer Pool

This block keeps track of which packet buffers are free for each traffic bundle. A fixed population of buffers, each identified by a buffer number, is split among a set of bundles. Every bundle owns a singly linked list of its free buffers. Each list has a head register that holds a validity flag and the number of the first free buffer. A link memory, with one entry per buffer, gives the next free buffer. A list ends at a buffer whose link names that same buffer, not at a null value.

Software fills the heads and links through an initialisation port before any traffic runs. After that, a consumer asks for a buffer from one bundle's list and gets the head buffer back one cycle later. A producer hands a finished buffer back to a bundle's list, where it becomes the new head. The lists therefore behave as last-in, first-out stacks. A separate combinational path turns a base address, a buffer number and a byte offset into a memory address. Each buffer is taken to be 2 KB.

Top module: `fbp_free_pool`

## Requirements
- R1: After reset every head is invalid, alloc_ack and alloc_empty_err are low, and any allocation returns alloc_empty_err until the lists are initialised.
- R2: An initialisation head write (init_head_we) sets the chosen head's validity flag and first-buffer number to init_head_valid and init_head_ptr.
- R3: An initialisation link write (init_link_we) sets the link of buffer init_link_idx to init_link_ptr.
- R4: An allocation from a list whose head is valid raises alloc_ack for one cycle, in the cycle after the request, with alloc_buf equal to the head buffer. The head then moves to that buffer's link.
- R5: If the allocated buffer links to itself, the list becomes empty. The next allocation from it reports alloc_empty_err.
- R6: An allocation from a list whose head is invalid raises alloc_empty_err for one cycle, in the cycle after the request, keeps alloc_ack low and leaves the list unchanged.
- R7: Freeing a buffer into an empty list makes a one-entry list. The next allocation returns that buffer, and the one after that reports empty.
- R8: Freeing a buffer into a non-empty list pushes it in front of the old head. Allocations then return the freed buffers newest first, followed by the previous contents.
- R9: When alloc_req and free_req arrive in the same cycle, only the free is carried out. In the following cycle, alloc_ack and alloc_empty_err are both low.
- R10: In a cycle with either initialisation write, allocation and free requests are ignored. The following cycle shows no acknowledge and no error, and the list contents are not changed by those requests.
- R11: addr_out equals addr_base + addr_buf × 2048 + addr_off, modulo 2^32, combinationally.
- R12: Operations on one list do not change any other list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_head_we | input | 1 | Head write strobe from software |
| init_head_idx | input | 6 | List whose head is written |
| init_head_valid | input | 1 | Validity flag to store |
| init_head_ptr | input | 9 | First free buffer to store |
| init_link_we | input | 1 | Link write strobe from software |
| init_link_idx | input | 9 | Buffer whose link is written |
| init_link_ptr | input | 9 | Next buffer to store |
| alloc_req | input | 1 | Allocation request |
| alloc_list | input | 6 | List to allocate from |
| alloc_ack | output | 1 | Buffer granted (one cycle after request) |
| alloc_buf | output | 9 | Granted buffer number |
| alloc_empty_err | output | 1 | Request hit an empty list |
| free_req | input | 1 | Free request |
| free_list | input | 6 | List that receives the buffer |
| free_buf | input | 9 | Buffer being returned |
| addr_base | input | 32 | Base of the buffer area |
| addr_buf | input | 9 | Buffer number for address forming |
| addr_off | input | 11 | Byte offset inside the buffer |
| addr_out | output | 32 | Formed memory address |

## Verification
The bench drains lists down to their last, self-linked entry. If the design missed the self-link test, it would keep handing out that last buffer again and again. It also frees into an empty list, where a design that wrote the old, stale head into the link would produce a list that never ends. It sends allocate and free in the same cycle, and sends requests together with initialisation writes. A design that gave the wrong side priority would grant a buffer or lose the returned one. Random traffic checked against a model of all the lists, plus address sums that wrap at the top of the address space, catches any leak between lists and any carry or shift error.

// File: rtl/fbp_pkg.sv
// Package fbp_pkg
// Shared types for the free buffer pool. The operation code is chosen once
// per cycle by the top level and steers both storage write ports.
package fbp_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INIT  = 2'd1,
        OP_FREE  = 2'd2,
        OP_ALLOC = 2'd3
    } fbp_op_e;
endpackage

// File: rtl/fbp_head_table.sv
// Module fbp_head_table
// Holds one head register per list: a validity flag and the number of the
// first free buffer. One combinational read port and one write port.
// Assumes that at most one write happens per cycle (the top serialises).
module fbp_head_table #(
    parameter int NUM_LISTS = 64,
    parameter int BUF_W     = 9,
    localparam int LIST_W   = $clog2(NUM_LISTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIST_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [BUF_W-1:0]  rd_ptr,
    input  logic              wr_en,
    input  logic [LIST_W-1:0] wr_idx,
    input  logic              wr_valid,
    input  logic [BUF_W-1:0]  wr_ptr
);
    logic [NUM_LISTS-1:0] vld_q;
    logic [BUF_W-1:0]     ptr_q [NUM_LISTS];

    // One register slice per list, reset to invalid.
    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_head
        // Update this list's head when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                ptr_q[g] <= '0;
            end else if (wr_en && (wr_idx == LIST_W'(g))) begin
                vld_q[g] <= wr_valid;
                ptr_q[g] <= wr_ptr;
            end
        end
    end

    // Present the selected head to the operation logic.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_ptr   = ptr_q[rd_idx];
    end

    // R2
    head_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)) &&
                  (ptr_q[$past(wr_idx)] == $past(wr_ptr)));

    // R12
    head_other_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != rd_idx)) |=> $stable(vld_q[$past(rd_idx)]));
endmodule

// File: rtl/fbp_link_mem.sv
// Module fbp_link_mem
// Next-buffer memory, one entry per buffer. Combinational read, one
// synchronous write per cycle. Contents are undefined until software
// initialises them, so no reset is applied to the array.
module fbp_link_mem #(
    parameter int NUM_BUF = 512,
    localparam int BUF_W  = $clog2(NUM_BUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUF_W-1:0] rd_addr,
    output logic [BUF_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [BUF_W-1:0] wr_addr,
    input  logic [BUF_W-1:0] wr_data
);
    logic [BUF_W-1:0] mem_q [NUM_BUF];

    // Store one link per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Return the link of the addressed buffer.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

    // R3
    link_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/fbp_addr_gen.sv
// Module fbp_addr_gen
// Forms a memory address from a base, a buffer number scaled by the buffer
// size (a power of two given as OFF_W) and an in-buffer offset. Purely
// combinational; the sum wraps at the address width.
module fbp_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int BUF_W  = 9,
    parameter int OFF_W  = 11
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BUF_W-1:0]  buf_num,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] scaled;

    // Scale the buffer number and add base and offset.
    always_comb begin
        scaled = ADDR_W'(buf_num) << OFF_W;
        addr   = base + scaled + ADDR_W'(offset);
    end
endmodule

// File: rtl/fbp_free_pool.sv
// Module fbp_free_pool
// Per-bundle free buffer lists. One operation per cycle in priority order:
// software initialisation, free, allocate. Allocation pops the head and
// reports one cycle later; a buffer linking to itself ends a list. Free
// pushes a buffer in front of the head. Assumes software never frees a
// buffer that is already on a list.
module fbp_free_pool
    import fbp_pkg::*;
#(
    parameter int NUM_BUF   = 512,
    parameter int NUM_LISTS = 64,
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 2048,
    localparam int BUF_W    = $clog2(NUM_BUF),
    localparam int LIST_W   = $clog2(NUM_LISTS),
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_head_we,
    input  logic [LIST_W-1:0] init_head_idx,
    input  logic              init_head_valid,
    input  logic [BUF_W-1:0]  init_head_ptr,
    input  logic              init_link_we,
    input  logic [BUF_W-1:0]  init_link_idx,
    input  logic [BUF_W-1:0]  init_link_ptr,
    input  logic              alloc_req,
    input  logic [LIST_W-1:0] alloc_list,
    output logic              alloc_ack,
    output logic [BUF_W-1:0]  alloc_buf,
    output logic              alloc_empty_err,
    input  logic              free_req,
    input  logic [LIST_W-1:0] free_list,
    input  logic [BUF_W-1:0]  free_buf,
    input  logic [ADDR_W-1:0] addr_base,
    input  logic [BUF_W-1:0]  addr_buf,
    input  logic [OFF_W-1:0]  addr_off,
    output logic [ADDR_W-1:0] addr_out
);
    fbp_op_e           op;
    logic [LIST_W-1:0] hd_rd_idx;
    logic              hd_valid;
    logic [BUF_W-1:0]  hd_ptr;
    logic              hd_we;
    logic [LIST_W-1:0] hd_wr_idx;
    logic              hd_wr_valid;
    logic [BUF_W-1:0]  hd_wr_ptr;
    logic [BUF_W-1:0]  lk_next;
    logic              lk_we;
    logic [BUF_W-1:0]  lk_wr_addr;
    logic [BUF_W-1:0]  lk_wr_data;
    logic              ack_q;
    logic              err_q;
    logic [BUF_W-1:0]  buf_q;

    // Pick the single operation for this cycle.
    always_comb begin
        if (init_head_we || init_link_we) begin
            op = OP_INIT;
        end else if (free_req) begin
            op = OP_FREE;
        end else if (alloc_req) begin
            op = OP_ALLOC;
        end else begin
            op = OP_NONE;
        end
        hd_rd_idx = (op == OP_FREE) ? free_list : alloc_list;
    end

    fbp_head_table #(
        .NUM_LISTS (NUM_LISTS),
        .BUF_W     (BUF_W)
    ) u_heads (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (hd_rd_idx),
        .rd_valid (hd_valid),
        .rd_ptr   (hd_ptr),
        .wr_en    (hd_we),
        .wr_idx   (hd_wr_idx),
        .wr_valid (hd_wr_valid),
        .wr_ptr   (hd_wr_ptr)
    );

    fbp_link_mem #(
        .NUM_BUF (NUM_BUF)
    ) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (hd_ptr),
        .rd_data (lk_next),
        .wr_en   (lk_we),
        .wr_addr (lk_wr_addr),
        .wr_data (lk_wr_data)
    );

    // Steer the head write port: init value, pushed buffer, or popped link.
    always_comb begin
        hd_we       = 1'b0;
        hd_wr_idx   = alloc_list;
        hd_wr_valid = 1'b0;
        hd_wr_ptr   = lk_next;
        unique case (op)
            OP_INIT: begin
                hd_we       = init_head_we;
                hd_wr_idx   = init_head_idx;
                hd_wr_valid = init_head_valid;
                hd_wr_ptr   = init_head_ptr;
            end
            OP_FREE: begin
                hd_we       = 1'b1;
                hd_wr_idx   = free_list;
                hd_wr_valid = 1'b1;
                hd_wr_ptr   = free_buf;
            end
            OP_ALLOC: begin
                hd_we       = hd_valid;
                hd_wr_idx   = alloc_list;
                hd_wr_valid = (lk_next != hd_ptr);
                hd_wr_ptr   = lk_next;
            end
            default: ;
        endcase
    end

    // Steer the link write port: init value or the freed buffer's new link.
    always_comb begin
        lk_we      = 1'b0;
        lk_wr_addr = free_buf;
        lk_wr_data = free_buf;
        if (op == OP_INIT) begin
            lk_we      = init_link_we;
            lk_wr_addr = init_link_idx;
            lk_wr_data = init_link_ptr;
        end else if (op == OP_FREE) begin
            lk_we      = 1'b1;
            lk_wr_data = hd_valid ? hd_ptr : free_buf;
        end
    end

    // Register the allocation result for the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            buf_q <= '0;
        end else begin
            ack_q <= (op == OP_ALLOC) && hd_valid;
            err_q <= (op == OP_ALLOC) && !hd_valid;
            if ((op == OP_ALLOC) && hd_valid) begin
                buf_q <= hd_ptr;
            end
        end
    end

    assign alloc_ack       = ack_q;
    assign alloc_empty_err = err_q;
    assign alloc_buf       = buf_q;

    fbp_addr_gen #(
        .ADDR_W (ADDR_W),
        .BUF_W  (BUF_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .base    (addr_base),
        .buf_num (addr_buf),
        .offset  (addr_off),
        .addr    (addr_out)
    );

    // R4
    ack_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ack && alloc_empty_err));

    // R6
    err_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_empty_err |-> $past(alloc_req));

    // R9
    free_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_req && alloc_req) |=> (!alloc_ack && !alloc_empty_err));

    // R10
    init_blocks_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_head_we || init_link_we) |=> (!alloc_ack && !alloc_empty_err));

    // R4
    served_alloc_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !free_req && !init_head_we && !init_link_we)
            |=> (alloc_ack || alloc_empty_err));
endmodule

// File: tb/tb_fbp_free_pool.sv
// Bench for fbp_free_pool: directed corner cases, then seeded random
// traffic, all compared with a behavioural model of the lists.
module tb_fbp_free_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_head_we = 1'b0;
    logic [5:0]  init_head_idx = '0;
    logic        init_head_valid = 1'b0;
    logic [8:0]  init_head_ptr = '0;
    logic        init_link_we = 1'b0;
    logic [8:0]  init_link_idx = '0;
    logic [8:0]  init_link_ptr = '0;
    logic        alloc_req = 1'b0;
    logic [5:0]  alloc_list = '0;
    logic        alloc_ack;
    logic [8:0]  alloc_buf;
    logic        alloc_empty_err;
    logic        free_req = 1'b0;
    logic [5:0]  free_list = '0;
    logic [8:0]  free_buf = '0;
    logic [31:0] addr_base = '0;
    logic [8:0]  addr_buf = '0;
    logic [10:0] addr_off = '0;
    logic [31:0] addr_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  m_vld [64];
    int  m_ptr [64];
    int  m_link [512];
    int  outs [512];
    int  n_out = 0;

    fbp_free_pool dut (
        .clk(clk), .rst_n(rst_n),
        .init_head_we(init_head_we), .init_head_idx(init_head_idx),
        .init_head_valid(init_head_valid), .init_head_ptr(init_head_ptr),
        .init_link_we(init_link_we), .init_link_idx(init_link_idx),
        .init_link_ptr(init_link_ptr),
        .alloc_req(alloc_req), .alloc_list(alloc_list), .alloc_ack(alloc_ack),
        .alloc_buf(alloc_buf), .alloc_empty_err(alloc_empty_err),
        .free_req(free_req), .free_list(free_list), .free_buf(free_buf),
        .addr_base(addr_base), .addr_buf(addr_buf), .addr_off(addr_off),
        .addr_out(addr_out)
    );

    always #10 clk = ~clk;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // One cycle of requests; the model decides the expected answer.
    task automatic run_op(bit a, int al, bit f, int fl, int fb,
                          bit ih, int hi, bit hv, int hp, string req);
        bit exp_ack = 0;
        bit exp_err = 0;
        int exp_buf = 0;
        if (ih) begin
            m_vld[hi] = hv;
            m_ptr[hi] = hp;
        end else if (f) begin
            m_link[fb] = m_vld[fl] ? m_ptr[fl] : fb;
            m_vld[fl]  = 1'b1;
            m_ptr[fl]  = fb;
            for (int i = 0; i < n_out; i++) begin
                if (outs[i] == fb) begin
                    outs[i] = outs[n_out-1];
                    n_out--;
                    break;
                end
            end
        end else if (a) begin
            if (m_vld[al]) begin
                exp_ack = 1'b1;
                exp_buf = m_ptr[al];
                if (m_link[exp_buf] == exp_buf) m_vld[al] = 1'b0;
                else m_ptr[al] = m_link[exp_buf];
                outs[n_out] = exp_buf;
                n_out++;
            end else begin
                exp_err = 1'b1;
            end
        end
        alloc_req = a; alloc_list = 6'(al);
        free_req = f; free_list = 6'(fl); free_buf = 9'(fb);
        init_head_we = ih; init_head_idx = 6'(hi);
        init_head_valid = hv; init_head_ptr = 9'(hp);
        @(negedge clk);
        check(alloc_ack == exp_ack, req, "alloc_ack", alloc_ack, exp_ack);
        check(alloc_empty_err == exp_err, req, "alloc_empty_err", alloc_empty_err, exp_err);
        if (exp_ack) check(alloc_buf == 9'(exp_buf), req, "alloc_buf", alloc_buf, exp_buf);
        alloc_req = 0; free_req = 0; init_head_we = 0;
    endtask

    task automatic link_write(int idx, int ptr);
        m_link[idx] = ptr;
        init_link_we = 1; init_link_idx = 9'(idx); init_link_ptr = 9'(ptr);
        @(negedge clk);
        init_link_we = 0;
    endtask

    task automatic addr_chk(logic [31:0] b, int bn, int off);
        logic [31:0] exp;
        addr_base = b; addr_buf = 9'(bn); addr_off = 11'(off);
        #1;
        exp = b + 32'(bn) * 32'd2048 + 32'(off);
        check(addr_out == exp, "R11", "addr_out", addr_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(alloc_ack == 0, "R1", "alloc_ack after reset", alloc_ack, 0);
        check(alloc_empty_err == 0, "R1", "err after reset", alloc_empty_err, 0);
        run_op(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        run_op(1, 63, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R2 R3: eight buffers per list, last one self-linked
        for (int b = 0; b < 512; b++) link_write(b, ((b % 8) == 7) ? b : b + 1);
        for (int l = 0; l < 64; l++) run_op(0, 0, 0, 0, 0, 1, l, 1, l * 8, "R2");

        // R4 R5: drain list 3 (24..31), then empty
        for (int k = 0; k < 8; k++) run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R4");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R6: repeated empty request leaves list empty
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R7: free into empty list
        run_op(0, 0, 1, 3, 24, 0, 0, 0, 0, "R7");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R7");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R8: two frees, newest first
        run_op(0, 0, 1, 3, 24, 0, 0, 0, 0, "R8");
        run_op(0, 0, 1, 3, 25, 0, 0, 0, 0, "R8");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R12: neighbour list untouched
        run_op(1, 4, 0, 0, 0, 0, 0, 0, 0, "R12");
        run_op(1, 2, 0, 0, 0, 0, 0, 0, 0, "R12");
        // R9: free wins over alloc
        run_op(1, 5, 1, 5, 24, 0, 0, 0, 0, "R9");
        run_op(1, 5, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R10: init head write blocks alloc and free
        run_op(1, 4, 1, 3, 25, 1, 4, 0, 0, "R10");
        run_op(1, 4, 0, 0, 0, 0, 0, 0, 0, "R10");
        run_op(1, 3, 0, 0, 0, 0, 0, 0, 0, "R10");

        // R11: directed wrap and zero cases
        addr_chk(32'hFFFF_F000, 511, 2047);
        addr_chk(32'h0, 0, 0);
        addr_chk(32'h1000_0000, 1, 5);

        // Random traffic
        for (int it = 0; it < 4000; it++) begin
            int r = int'($urandom % 8);
            int l = int'($urandom % 64);
            int l2 = int'($urandom % 64);
            if (r < 4) begin
                run_op(1, l, 0, 0, 0, 0, 0, 0, 0, "R4");
            end else if (r < 6 && n_out > 0) begin
                run_op(0, 0, 1, l, outs[int'($urandom % n_out)], 0, 0, 0, 0, "R8");
            end else if (r == 6 && n_out > 0) begin
                run_op(1, l2, 1, l, outs[int'($urandom % n_out)], 0, 0, 0, 0, "R9");
            end else begin
                addr_chk($urandom, int'($urandom % 512), int'($urandom % 2048));
            end
        end
        summary();
    end
endmodule